// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block decides which of eight interrupt request lines should be presented to the processor next. Each cycle it takes three vectors: the pending requests, the mask and the in-service set. It also takes a rotation base, which sets the line that currently holds top priority, and three mode straps. From these it finds the highest-ranked unmasked pending line. It then ranks the in-service set the same way and raises the interrupt output only when the new candidate strictly outranks every level still being serviced.

Ranking is circular. The line named by the rotation base ranks first, the line above it ranks second, and so on, wrapping from 7 back to 0. Two mode straps change which in-service bits count in the comparison. With the masked-service strap set, in-service bits of masked lines are ignored. With the nested-cascade strap set on a master-strapped instance, the in-service bit of the cascade line (line 2) is ignored, so a second request arriving through the cascade can still interrupt. Capturing requests, acknowledging them and programming the registers are handled elsewhere. All three outputs are registered.

Top module: `prio_resolver`

## Requirements
- R1: The candidate set is `pend_i & ~mask_i`. When it is empty, `cand_valid_o` is 0, `line_o` is 0 and `irq_o` is 0.
- R2: Rank is circular from `rot_base_i`. Line `rot_base_i` has rank 0 (best), line `(rot_base_i+1) mod 8` has rank 1, and so on up to rank 7.
- R3: When the candidate set is non-empty, `cand_valid_o` is 1 and `line_o` gives the binary number of the candidate line with the best rank.
- R4: The in-service level is ranked in the same circular order. `irq_o` is 1 only if the candidate's rank is strictly better than the best in-service rank. An equal or worse rank gives 0.
- R5: With no in-service bit counted, any candidate sets `irq_o` to 1.
- R6: With `spec_mask_i` = 1, in-service bits of lines masked in `mask_i` are left out of the in-service ranking. With `spec_mask_i` = 0, they count.
- R7: With `spec_nest_i` = 1 and `is_master_i` = 1, in-service bit 2 is left out of the in-service ranking. If either strap is 0, it counts.
- R8: Each output reflects the inputs sampled at the previous rising clock edge. A change on the inputs shows on the outputs exactly one cycle later, including deassertion.
- R9: While `rst_n` is low, all outputs are 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector, 1 = line blocked |
| isr_i | input | 8 | In-service vector |
| rot_base_i | input | 3 | Line that currently holds top rank |
| spec_mask_i | input | 1 | Leave masked lines out of the in-service ranking |
| spec_nest_i | input | 1 | Leave the cascade line out of the in-service ranking (master only) |
| is_master_i | input | 1 | Strap: instance is the master of a cascade |
| cand_valid_o | output | 1 | An unmasked request is pending |
| line_o | output | 3 | Best-ranked unmasked pending line |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions check a set of rules on every cycle against the previous cycle's inputs:
- an interrupt never occurs without a candidate;
- an idle result reports line 0;
- the reported line was unmasked and pending;
- the line at the rotation base always wins when it is a candidate;
- an in-service bit at the rotation base, when it counts, blocks the interrupt;
- an empty in-service set lets any candidate through.

The full ranking cannot be captured by those local rules. That covers the arbitrary winner under every rotation, equal-versus-worse rank comparisons at other positions, and how the two mode straps interact. The bench's directed table and its model-compared random sweep over all eight rotation bases are what show these. The bench also shows the reset values and the one-cycle latency.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;

    // Default geometry of one controller
    localparam int unsigned PR_LINES   = 8;
    localparam int unsigned PR_CASCADE = 2;

    // Mode straps that alter the in-service ranking
    typedef struct packed {
        logic spec_mask;
        logic spec_nest;
        logic is_master;
    } pr_mode_t;

endpackage

// File: rtl/pr_rot_scan.sv
// Circular priority scan: returns the rank of the best set bit counted
// upward from base_i, or N when the vector is empty.
module pr_rot_scan #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] base_i,
    output logic [W:0]   rank_o
);

    logic [N-1:0] rot;

    always_comb begin
        logic [W-1:0] idx;
        for (int i = 0; i < N; i++) begin
            idx    = W'(i) + base_i;
            rot[i] = vec_i[idx];
        end
    end

    always_comb begin
        rank_o = (W+1)'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                rank_o = (W+1)'(i);
            end
        end
    end

endmodule

// File: rtl/pr_isr_filter.sv
// Removes in-service bits that must not count toward the current level.
module pr_isr_filter
    import prio_res_pkg::*;
#(
    parameter int unsigned N       = 8,
    parameter int unsigned CASCADE = 2
) (
    input  logic [N-1:0] isr_i,
    input  logic [N-1:0] mask_i,
    input  pr_mode_t     mode_i,
    output logic [N-1:0] isr_o
);

    logic [N-1:0] after_mask;

    assign after_mask = mode_i.spec_mask ? (isr_i & ~mask_i) : isr_i;

    generate
        if (CASCADE < N) begin : g_cascade
            always_comb begin
                isr_o = after_mask;
                if (mode_i.spec_nest && mode_i.is_master) begin
                    isr_o[CASCADE] = 1'b0;
                end
            end
        end else begin : g_no_cascade
            assign isr_o = after_mask;
        end
    endgenerate

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter int unsigned NUM_LINES    = PR_LINES,
    parameter int unsigned CASCADE_LINE = PR_CASCADE,
    localparam int unsigned IDX_W       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] isr_i,
    input  logic [IDX_W-1:0]     rot_base_i,
    input  logic                 spec_mask_i,
    input  logic                 spec_nest_i,
    input  logic                 is_master_i,
    output logic                 cand_valid_o,
    output logic [IDX_W-1:0]     line_o,
    output logic                 irq_o
);

    localparam logic [IDX_W:0] RANK_NONE = (IDX_W+1)'(NUM_LINES);

    typedef struct packed {
        logic             cand_valid;
        logic [IDX_W-1:0] line;
        logic             irq;
    } res_t;

    res_t res_d, res_q;

    pr_mode_t             mode;
    logic [NUM_LINES-1:0] cand_vec;
    logic [NUM_LINES-1:0] serv_vec;
    logic [IDX_W:0]       cand_rank;
    logic [IDX_W:0]       serv_rank;

    assign mode     = '{spec_mask: spec_mask_i, spec_nest: spec_nest_i, is_master: is_master_i};
    assign cand_vec = pend_i & ~mask_i;

    pr_isr_filter #(
        .N       (NUM_LINES),
        .CASCADE (CASCADE_LINE)
    ) u_isr_filter (
        .isr_i  (isr_i),
        .mask_i (mask_i),
        .mode_i (mode),
        .isr_o  (serv_vec)
    );

    pr_rot_scan #(.N(NUM_LINES)) u_cand_scan (
        .vec_i  (cand_vec),
        .base_i (rot_base_i),
        .rank_o (cand_rank)
    );

    pr_rot_scan #(.N(NUM_LINES)) u_serv_scan (
        .vec_i  (serv_vec),
        .base_i (rot_base_i),
        .rank_o (serv_rank)
    );

    always_comb begin
        res_d = '0;
        if (cand_rank != RANK_NONE) begin
            res_d.cand_valid = 1'b1;
            res_d.line       = cand_rank[IDX_W-1:0] + rot_base_i;
            res_d.irq        = (cand_rank < serv_rank);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign cand_valid_o = res_q.cand_valid;
    assign line_o       = res_q.line;
    assign irq_o        = res_q.irq;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int unsigned NUM_LINES    = 8,
    parameter int unsigned CASCADE_LINE = 2,
    localparam int unsigned IDX_W       = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] pend_i,
    input logic [NUM_LINES-1:0] mask_i,
    input logic [NUM_LINES-1:0] isr_i,
    input logic [IDX_W-1:0]     rot_base_i,
    input logic                 spec_mask_i,
    input logic                 spec_nest_i,
    input logic                 is_master_i,
    input logic                 cand_valid_o,
    input logic [IDX_W-1:0]     line_o,
    input logic                 irq_o
);

    logic base_is_cand;
    logic base_in_serv_counts;

    assign base_is_cand        = |((pend_i & ~mask_i) & (NUM_LINES'(1) << rot_base_i));
    assign base_in_serv_counts = isr_i[rot_base_i] && !spec_mask_i &&
                                 !(spec_nest_i && is_master_i &&
                                   (32'(rot_base_i) == CASCADE_LINE));

    AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cand_valid_o);                                              // R4

    AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid_o |-> (line_o == '0));                                    // R1

    AST_NO_CAND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~mask_i) == '0) |=> (!cand_valid_o && !irq_o));            // R1

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        base_is_cand || 1'b1 |=> (!cand_valid_o ||
            |(($past(pend_i) & ~$past(mask_i)) & (NUM_LINES'(1) << line_o)))); // R3

    AST_BASE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        base_is_cand |=> (cand_valid_o && line_o == $past(rot_base_i)));     // R2

    AST_BASE_SERV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        base_in_serv_counts |=> !irq_o);                                      // R4

    AST_EMPTY_SERV_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_i & ~mask_i) != '0) && (isr_i == '0)) |=> irq_o);             // R5

endmodule

bind prio_resolver prio_resolver_chk #(
    .NUM_LINES    (NUM_LINES),
    .CASCADE_LINE (CASCADE_LINE)
) u_chk (.*);

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pend_i = '0, mask_i = '0, isr_i = '0;
    logic [2:0] rot_base_i = '0;
    logic       spec_mask_i = 1'b0, spec_nest_i = 1'b0, is_master_i = 1'b0;
    logic       cand_valid_o, irq_o;
    logic [2:0] line_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    prio_resolver dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i), .isr_i(isr_i),
        .rot_base_i(rot_base_i), .spec_mask_i(spec_mask_i), .spec_nest_i(spec_nest_i),
        .is_master_i(is_master_i), .cand_valid_o(cand_valid_o), .line_o(line_o),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0] pend;
        logic [7:0] mask;
        logic [7:0] isr;
        logic [2:0] base;
        logic       smm;
        logic       snest;
        logic       mst;
        logic       e_valid;
        logic [2:0] e_line;
        logic       e_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1}, // R1 all masked
        '{8'h00, 8'h00, 8'hFF, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1}, // R1 nothing pending
        '{8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd2}, // R2 base 0
        '{8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 4'd2}, // R2 base 1
        '{8'h11, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd2}, // R2 wrap
        '{8'h28, 8'h08, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 4'd3}, // R3 masked skip
        '{8'h80, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 4'd5}, // R5 lowest rank
        '{8'h10, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 4'd4}, // R4 equal rank
        '{8'h04, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 4'd4}, // R4 better
        '{8'h40, 8'h00, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 4'd4}, // R4 worse
        '{8'h01, 8'h00, 8'h80, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd4}, // R4 rotated worse
        '{8'h40, 8'h00, 8'h01, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 1'b1, 4'd4}, // R4 rotated better
        '{8'h20, 8'h08, 8'h08, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 4'd6}, // R6 on
        '{8'h20, 8'h08, 8'h08, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 4'd6}, // R6 off
        '{8'h10, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 1'b1, 4'd7}, // R7 master
        '{8'h10, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, 4'd7}, // R7 slave
        '{8'h10, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 4'd7}, // R7 strap off
        '{8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 1'b1, 4'd7}, // R7 cascade again
        '{8'h24, 8'h00, 8'h00, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 4'd3}, // R3 rotated pick
        '{8'h00, 8'hFF, 8'h00, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 4'd1}  // R1 idle, straps
    };

    // Independent reference: walk ranks from best to worst
    function automatic logic [4:0] ref_model(input logic [7:0] p, m, s, input logic [2:0] b,
                                             input logic smm, sn, ms);
        logic [7:0] c, sv;
        int cr, sr;
        logic [2:0] ln;
        c  = p & ~m;
        sv = smm ? (s & ~m) : s;
        if (sn && ms) sv[2] = 1'b0;
        cr = 8;
        sr = 8;
        for (int r = 7; r >= 0; r--) begin
            ln = 3'(int'(b) + r);
            if (c[ln])  cr = r;
            if (sv[ln]) sr = r;
        end
        if (cr == 8) return 5'b0;
        return {1'b1, 3'(int'(b) + cr), cr < sr};
    endfunction

    task automatic drive(input logic [7:0] p, m, s, input logic [2:0] b,
                         input logic smm, sn, ms);
        pend_i = p; mask_i = m; isr_i = s; rot_base_i = b;
        spec_mask_i = smm; spec_nest_i = sn; is_master_i = ms;
    endtask

    task automatic check(input string tag, input logic ev, input logic [2:0] el, input logic ei);
        n_chk++;
        if (cand_valid_o !== ev || line_o !== el || irq_o !== ei) begin
            n_bad++;
            $display("FAIL %s: got valid=%b line=%0d irq=%b, expected valid=%b line=%0d irq=%b",
                     tag, cand_valid_o, line_o, irq_o, ev, el, ei);
        end
    endtask

    initial begin
        // R9: reset holds outputs low with live inputs
        drive(8'hFF, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 first cycle after reset", 1'b1, 3'd0, 1'b1);

        // Directed table
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].pend, TBL[k].mask, TBL[k].isr, TBL[k].base,
                  TBL[k].smm, TBL[k].snest, TBL[k].mst);
            @(negedge clk);
            check($sformatf("R%0d table row %0d", TBL[k].req, k),
                  TBL[k].e_valid, TBL[k].e_line, TBL[k].e_irq);
        end

        // R8: one-cycle latency on assert and deassert
        drive(8'h08, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 assert", 1'b1, 3'd3, 1'b1);
        drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
        #5;
        check("R8 old value held before edge", 1'b1, 3'd3, 1'b1);
        @(negedge clk);
        check("R8 deassert next cycle", 1'b0, 3'd0, 1'b0);

        // Random sweep over all rotation bases, compared with the model (R2 R3 R4 R6 R7)
        for (int b = 0; b < 8; b++) begin
            for (int n = 0; n < 250; n++) begin
                logic [7:0] p, m, s;
                logic [2:0] fl;
                logic [4:0] e;
                p  = 8'($urandom);
                m  = 8'($urandom) & 8'($urandom);
                s  = 8'($urandom) & 8'($urandom);
                fl = 3'($urandom);
                drive(p, m, s, 3'(b), fl[0], fl[1], fl[2]);
                e = ref_model(p, m, s, 3'(b), fl[0], fl[1], fl[2]);
                @(negedge clk);
                check($sformatf("R4 random base=%0d p=%h m=%h s=%h f=%b", b, p, m, s, fl),
                      e[4], e[3:1], e[0]);
            end
        end

        // R9: asynchronous reset mid-run
        drive(8'h01, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R9 async reset", 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule